// File: doc/BRIEF.md
# Display PLL Divisor Search Engine

This block searches exhaustively for the PLL divider settings that bring a display pixel clock closest to a requested frequency in kHz. It has two modes. Panel mode sweeps a feedback multiplier m and a post divider p1 against a reference taken from the selected core frequency. Serial-video mode sweeps m, an input pre-divider n and p1. Each candidate must fit a VCO window, and it is scored by its error in parts per 10000. Every quotient comes from a shared bit-serial restoring divider, so a search takes a few thousand to a few tens of thousands of cycles.

Software or a mode-set sequencer loads the mode, the core-frequency select and the target, then pulses `start`. When `done` rises, the result is ready. The result has a success flag, the raw winning divisors and two packed words, one for the divisor register and one for the PLL control register. All of these stay frozen until the next accepted start.

Top module: `pll_divisor_search`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0, and `m_out`, `n_out`, `p1_out`, `fp_word` and `dpll_word` are all 0.
- R2: In panel mode the reference is 100000 kHz for `core_sel`=0, 166000 for 1, and 200000 for 2 or 3. The m range is 20..34, 12..20 and 10..17 for those selects. The p1 range is 2..7 for select 1 and 2..8 otherwise. The output clock is floor(ref*m/(14*p1)).
- R3: The panel search walks m in the outer loop and p1 in the inner loop, both ascending. A candidate replaces the best only when its absolute error is strictly smaller, so on a tie the earlier candidate is kept. `found` is 1 exactly when the final best error is below the target.
- R4: In serial mode the reference is 96000 kHz. The search walks m 80..137 in the outer loop, n 3..7 in the middle loop and p1 1..2 in the inner loop, with p = 10*p1. If target*p exceeds 2800000, the rest of the p1 loop is abandoned. If target*p is below 1400000, the candidate is skipped.
- R5: In serial mode the actual clock is floor(96000*m/(n*p)), and the signed error is 10000 - floor(target*10000/actual). A signed error below the negative of the current best abandons the rest of the p1 loop. Otherwise a strictly smaller magnitude becomes the new best. The best starts at 100000. The m loop stops after an n pass that ends with a best of 0, and `found` is 1 exactly when the best is 0.
- R6: In panel mode, `fp_word[13:8]` holds a 6-bit code for m and all other bits are 0. The code for m=10 is 0x2B. Each following m takes the previous code shifted right by one, with the new bit 5 equal to bit 0 XOR bit 5 of the previous code. `dpll_word` has only bit 15+p1 set.
- R7: In serial mode, `fp_word` has bit 15+n set and m-2 in bits [7:0]. `dpll_word` has only bit 15+p1 set. `n_out` is 0 in panel mode.
- R8: When no candidate is ever accepted, `m_out`, `n_out`, `p1_out`, `fp_word` and `dpll_word` are all 0.
- R9: A `start` pulse while `busy` is 1 is ignored. The running search completes with the inputs it latched at its own start.
- R10: `done` and `busy` are never both 1. Once `done` is 1, it and every result output hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; accepted only when idle |
| mode_serial | input | 1 | 0 = panel mode, 1 = serial-video mode |
| core_sel | input | 2 | Core frequency select for panel mode |
| target_khz | input | TW (20) | Requested pixel clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until next start |
| found | output | 1 | Panel: some candidate beat the initial error; serial: exact match |
| m_out | output | 8 | Winning multiplier |
| n_out | output | 4 | Winning pre-divider (serial mode only) |
| p1_out | output | 4 | Winning post divider |
| fp_word | output | 32 | Packed divisor register word |
| dpll_word | output | 32 | Packed PLL control word (p1 field) |

## Verification
The assertions assume that `target_khz` stays at or below 280000 whenever a serial candidate reaches scoring. Under that bound target*10000 fits the datapath, and no actual clock can be zero, so the divider never receives a zero divisor. The VCO window enforces the bound on its own, because any target above 280000 fails the window check before it is scored. The stimulus also keeps panel targets in the low hundreds of thousands of kHz. The busy-start check drives new inputs in the middle of a search, and the assertions require the latched inputs to stay put during that search.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int VCO_MIN_KHZ     = 1400000;
    localparam int VCO_MAX_KHZ     = 2800000;
    localparam int ERR_SCALE       = 10000;
    localparam int SERIAL_ERR_INIT = 100000;
    localparam int PANEL_PDIV      = 14;
    localparam int SERIAL_P2       = 10;

    localparam logic [7:0] M_CODE_BASE = 8'd10;
    localparam logic [5:0] M_CODE_SEED = 6'h2B;
    localparam int         M_CODE_SPAN = 26;

    localparam int PANEL_CODE_LSB = 8;
    localparam int PANEL_P1_LSB   = 17;
    localparam int SER_N_LSB      = 16;
    localparam int SER_P1_LSB     = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WAIT_A,
        ST_WAIT_B,
        ST_SCORE,
        ST_STEP
    } sweep_state_e;

    typedef struct packed {
        logic [7:0]  m_lo;
        logic [7:0]  m_hi;
        logic [3:0]  n_lo;
        logic [3:0]  n_hi;
        logic [3:0]  p1_lo;
        logic [3:0]  p1_hi;
        logic [17:0] ref_khz;
    } sweep_lim_t;

    typedef struct packed {
        logic [7:0] m;
        logic [3:0] n;
        logic [3:0] p1;
    } divset_t;

    function automatic sweep_lim_t limits_for(input logic serial, input logic [1:0] core);
        sweep_lim_t l;
        if (serial) begin
            l = '{m_lo: 8'd80, m_hi: 8'd137, n_lo: 4'd3, n_hi: 4'd7,
                  p1_lo: 4'd1, p1_hi: 4'd2, ref_khz: 18'd96000};
        end else begin
            case (core)
                2'd0:    l = '{m_lo: 8'd20, m_hi: 8'd34, n_lo: 4'd0, n_hi: 4'd0,
                               p1_lo: 4'd2, p1_hi: 4'd8, ref_khz: 18'd100000};
                2'd1:    l = '{m_lo: 8'd12, m_hi: 8'd20, n_lo: 4'd0, n_hi: 4'd0,
                               p1_lo: 4'd2, p1_hi: 4'd7, ref_khz: 18'd166000};
                default: l = '{m_lo: 8'd10, m_hi: 8'd17, n_lo: 4'd0, n_hi: 4'd0,
                               p1_lo: 4'd2, p1_hi: 4'd8, ref_khz: 18'd200000};
            endcase
        end
        return l;
    endfunction

    // Panel multiplier code: a 6-bit shift sequence, one step per m above the base.
    function automatic logic [5:0] panel_m_code(input logic [7:0] m);
        logic [5:0] c;
        c = M_CODE_SEED;
        for (int i = 0; i < M_CODE_SPAN - 1; i++) begin
            if (8'(i) < (m - M_CODE_BASE)) c = {c[0] ^ c[5], c[5:1]};
        end
        return c;
    endfunction

endpackage

// File: rtl/pll_div_unit.sv
module pll_div_unit #(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;

    logic [W:0] shifted;
    logic       ge;
    logic [W:0] rem_next;

    always_comb begin
        shifted  = {rem_q[W-1:0], quo_q[W-1]};
        ge       = shifted >= {1'b0, dvs_q};
        rem_next = ge ? (shifted - {1'b0, dvs_q}) : shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_next;
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // R4: the operand ranges never produce a zero divisor
    a_r4_divisor_nonzero: assert property (@(posedge clk) disable iff (rst)
        start |-> (divisor != '0));

    // R4: the controller never restarts an operation in flight
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        start |-> !run_q);

endmodule

// File: rtl/pll_sweep_ctrl.sv
module pll_sweep_ctrl
    import pll_search_pkg::*;
#(
    parameter int TW = 20,
    parameter int DW = TW + 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode_serial,
    input  logic [1:0]    core_sel,
    input  logic [TW-1:0] target,
    output logic          div_start,
    output logic [DW-1:0] div_dividend,
    output logic [DW-1:0] div_divisor,
    input  logic          div_done,
    input  logic [DW-1:0] div_q,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic          have,
    output logic          serial_q,
    output divset_t       best
);
    sweep_state_e  state;
    logic [1:0]    core_q;
    logic [TW-1:0] tgt_q;
    logic [7:0]    m_q;
    logic [3:0]    n_q;
    logic [3:0]    p1_q;
    logic          brk_q;
    logic [DW-1:0] best_err;

    sweep_lim_t lim;
    sweep_lim_t lim_in;
    logic [DW-1:0] vco;
    logic          vco_hi, vco_lo;
    logic [DW-1:0] panel_err;
    logic signed [DW+1:0] ferr;
    logic signed [DW+1:0] ferr_floor;
    logic [DW+1:0] ferr_mag;
    logic          serial_prune, serial_better, panel_better;

    always_comb begin
        lim    = limits_for(serial_q, core_q);
        lim_in = limits_for(mode_serial, core_sel);
        vco    = DW'(tgt_q) * DW'(p1_q) * DW'(SERIAL_P2);
        vco_hi = vco > DW'(VCO_MAX_KHZ);
        vco_lo = vco < DW'(VCO_MIN_KHZ);

        div_start = ((state == ST_EVAL) && !(serial_q && (vco_hi || vco_lo)))
                 || ((state == ST_WAIT_A) && div_done && serial_q);
        if (state == ST_WAIT_A) begin
            div_dividend = DW'(tgt_q) * DW'(ERR_SCALE);
            div_divisor  = div_q;
        end else begin
            div_dividend = DW'(lim.ref_khz) * DW'(m_q);
            div_divisor  = serial_q ? DW'(n_q) * DW'(p1_q) * DW'(SERIAL_P2)
                                    : DW'(p1_q) * DW'(PANEL_PDIV);
        end

        panel_err = (div_q >= DW'(tgt_q)) ? (div_q - DW'(tgt_q)) : (DW'(tgt_q) - div_q);
        panel_better = panel_err < best_err;

        ferr          = $signed({2'b00, DW'(ERR_SCALE)}) - $signed({2'b00, div_q});
        ferr_floor    = -$signed({2'b00, best_err});
        ferr_mag      = ferr[DW+1] ? $unsigned(-ferr) : $unsigned(ferr);
        serial_prune  = ferr < ferr_floor;
        serial_better = ferr_mag < {2'b00, best_err};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            serial_q <= 1'b0;
            core_q   <= '0;
            tgt_q    <= '0;
            m_q      <= '0;
            n_q      <= '0;
            p1_q     <= '0;
            brk_q    <= 1'b0;
            best_err <= '0;
            best     <= '0;
            have     <= 1'b0;
            done     <= 1'b0;
            found    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    serial_q <= mode_serial;
                    core_q   <= core_sel;
                    tgt_q    <= target;
                    done     <= 1'b0;
                    found    <= 1'b0;
                    have     <= 1'b0;
                    best     <= '0;
                    brk_q    <= 1'b0;
                    best_err <= mode_serial ? DW'(SERIAL_ERR_INIT) : DW'(target);
                    m_q      <= lim_in.m_lo;
                    n_q      <= lim_in.n_lo;
                    p1_q     <= lim_in.p1_lo;
                    state    <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (serial_q && vco_hi) begin
                        brk_q <= 1'b1;
                        state <= ST_STEP;
                    end else if (serial_q && vco_lo) begin
                        brk_q <= 1'b0;
                        state <= ST_STEP;
                    end else begin
                        state <= ST_WAIT_A;
                    end
                end
                ST_WAIT_A: if (div_done) state <= serial_q ? ST_WAIT_B : ST_SCORE;
                ST_WAIT_B: if (div_done) state <= ST_SCORE;
                ST_SCORE: begin
                    brk_q <= 1'b0;
                    if (serial_q) begin
                        if (serial_prune) begin
                            brk_q <= 1'b1;
                        end else if (serial_better) begin
                            best_err <= ferr_mag[DW-1:0];
                            best     <= '{m: m_q, n: n_q, p1: p1_q};
                            have     <= 1'b1;
                        end
                    end else if (panel_better) begin
                        best_err <= panel_err;
                        best     <= '{m: m_q, n: 4'd0, p1: p1_q};
                        have     <= 1'b1;
                    end
                    state <= ST_STEP;
                end
                ST_STEP: begin
                    state <= ST_EVAL;
                    if (!brk_q && (p1_q < lim.p1_hi)) begin
                        p1_q <= p1_q + 4'd1;
                    end else begin
                        p1_q <= lim.p1_lo;
                        if (serial_q && (n_q < lim.n_hi)) begin
                            n_q <= n_q + 4'd1;
                        end else begin
                            n_q <= lim.n_lo;
                            if ((serial_q && (best_err == '0)) || (m_q >= lim.m_hi)) begin
                                done  <= 1'b1;
                                found <= serial_q ? (best_err == '0) : (best_err != DW'(tgt_q));
                                state <= ST_IDLE;
                            end else begin
                                m_q <= m_q + 8'd1;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R9: a start seen while busy leaves the latched request untouched
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(tgt_q) && $stable(serial_q) && $stable(core_q)));

    // R10: results hold from done until the next start
    a_r10_hold_results: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(best) && $stable(found) && $stable(have)));

    // R10: done and busy are exclusive
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R4: every scored serial candidate sits inside the VCO window
    a_r4_vco_window: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SCORE) && serial_q) |-> (!vco_hi && !vco_lo));

    // R2: panel sweep stays inside the selected limits
    a_r2_panel_range: assert property (@(posedge clk) disable iff (rst)
        (busy && !serial_q) |->
            ((m_q >= lim.m_lo) && (m_q <= lim.m_hi) && (p1_q >= lim.p1_lo) && (p1_q <= lim.p1_hi)));

endmodule

// File: rtl/pll_word_pack.sv
module pll_word_pack
    import pll_search_pkg::*;
(
    input  logic        serial,
    input  logic        have,
    input  divset_t     ds,
    output logic [31:0] fp_word,
    output logic [31:0] dpll_word
);
    always_comb begin
        fp_word   = '0;
        dpll_word = '0;
        if (have) begin
            if (serial) begin
                fp_word   = (32'd1 << (5'(ds.n) - 5'd1 + 5'(SER_N_LSB))) | 32'(ds.m - 8'd2);
                dpll_word = 32'd1 << (5'(ds.p1) - 5'd1 + 5'(SER_P1_LSB));
            end else begin
                fp_word   = 32'(panel_m_code(ds.m)) << PANEL_CODE_LSB;
                dpll_word = 32'd1 << (5'(ds.p1) - 5'd2 + 5'(PANEL_P1_LSB));
            end
        end
    end
endmodule

// File: rtl/pll_divisor_search.sv
module pll_divisor_search
    import pll_search_pkg::*;
#(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode_serial,
    input  logic [1:0]    core_sel,
    input  logic [TW-1:0] target_khz,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic [7:0]    m_out,
    output logic [3:0]    n_out,
    output logic [3:0]    p1_out,
    output logic [31:0]   fp_word,
    output logic [31:0]   dpll_word
);
    localparam int DW = TW + 14;

    logic          div_start, div_done;
    logic [DW-1:0] div_dividend, div_divisor, div_q;
    logic          have, serial_q;
    divset_t       best;

    pll_div_unit #(.W(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .done     (div_done),
        .quotient (div_q)
    );

    pll_sweep_ctrl #(.TW(TW), .DW(DW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode_serial  (mode_serial),
        .core_sel     (core_sel),
        .target       (target_khz),
        .div_start    (div_start),
        .div_dividend (div_dividend),
        .div_divisor  (div_divisor),
        .div_done     (div_done),
        .div_q        (div_q),
        .busy         (busy),
        .done         (done),
        .found        (found),
        .have         (have),
        .serial_q     (serial_q),
        .best         (best)
    );

    pll_word_pack u_pack (
        .serial    (serial_q),
        .have      (have),
        .ds        (best),
        .fp_word   (fp_word),
        .dpll_word (dpll_word)
    );

    assign m_out  = best.m;
    assign n_out  = best.n;
    assign p1_out = best.p1;

    // R8: with no accepted candidate both packed words are empty
    a_r8_empty_words: assert property (@(posedge clk) disable iff (rst)
        (done && !have) |-> ((fp_word == '0) && (dpll_word == '0)));

    // R6: a panel result always carries exactly one p1 bit
    a_r6_onehot_p1: assert property (@(posedge clk) disable iff (rst)
        (done && have) |-> ($countones(dpll_word) == 1));

endmodule

// File: tb/tb_pll_divisor_search.sv
`timescale 1ns/1ps
module tb_pll_divisor_search;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode_serial = 1'b0;
    logic [1:0]  core_sel = 2'd0;
    logic [19:0] target_khz = '0;
    logic        busy, done, found;
    logic [7:0]  m_out;
    logic [3:0]  n_out, p1_out;
    logic [31:0] fp_word, dpll_word;

    always #2 clk = ~clk;

    pll_divisor_search dut (
        .clk(clk), .rst(rst), .start(start), .mode_serial(mode_serial),
        .core_sel(core_sel), .target_khz(target_khz), .busy(busy), .done(done),
        .found(found), .m_out(m_out), .n_out(n_out), .p1_out(p1_out),
        .fp_word(fp_word), .dpll_word(dpll_word)
    );

    int checks = 0;
    int failures = 0;

    typedef struct {
        int  m;
        int  n;
        int  p1;
        bit  found;
        bit  have;
    } res_t;

    typedef struct packed {
        logic        serial;
        logic [1:0]  core;
        logic [19:0] tgt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 20'd65000},
        '{1'b0, 2'd1, 20'd71250},
        '{1'b0, 2'd2, 20'd33000},
        '{1'b0, 2'd3, 20'd100000},
        '{1'b0, 2'd0, 20'd5},
        '{1'b1, 2'd0, 20'd120000},
        '{1'b1, 2'd2, 20'd101234},
        '{1'b1, 2'd1, 20'd50000},
        '{1'b1, 2'd0, 20'd148500}
    };

    localparam logic [5:0] CODE_TAB [26] = '{
        6'h2B, 6'h15, 6'h2A, 6'h35, 6'h1A, 6'h0D, 6'h26, 6'h33, 6'h19, 6'h2C,
        6'h36, 6'h3B, 6'h1D, 6'h2E, 6'h37, 6'h1B, 6'h2D, 6'h16, 6'h0B, 6'h25,
        6'h12, 6'h09, 6'h24, 6'h32, 6'h39, 6'h1C
    };

    function automatic res_t model(bit serial, int core, longint tgt);
        res_t r;
        longint err, refk, dot, e, vco, act, fe;
        int mlo, mhi, p1hi;
        r = '{default: 0};
        if (!serial) begin
            case (core)
                0:       begin refk = 100000; mlo = 20; mhi = 34; p1hi = 8; end
                1:       begin refk = 166000; mlo = 12; mhi = 20; p1hi = 7; end
                default: begin refk = 200000; mlo = 10; mhi = 17; p1hi = 8; end
            endcase
            err = tgt;
            for (int m = mlo; m <= mhi; m++) begin
                for (int p1 = 2; p1 <= p1hi; p1++) begin
                    dot = (refk * m) / (14 * p1);
                    e = (dot > tgt) ? dot - tgt : tgt - dot;
                    if (e < err) begin
                        err = e; r.m = m; r.n = 0; r.p1 = p1; r.have = 1'b1;
                    end
                end
            end
            r.found = (err != tgt);
        end else begin
            err = 100000;
            for (int m = 80; m <= 137; m++) begin
                for (int n = 3; n <= 7; n++) begin
                    for (int p1 = 1; p1 <= 2; p1++) begin
                        vco = tgt * p1 * 10;
                        if (vco > 2800000) break;
                        if (vco < 1400000) continue;
                        act = (longint'(96000) * m) / (n * p1 * 10);
                        fe = 10000 - (tgt * 10000) / act;
                        if (fe < -err) break;
                        if (fe < 0) fe = -fe;
                        if (fe < err) begin
                            err = fe; r.m = m; r.n = n; r.p1 = p1; r.have = 1'b1;
                        end
                    end
                end
                if (err == 0) break;
            end
            r.found = (err == 0);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        ok = 1'b0;
        while (n < 60000) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
            n++;
        end
    endtask

    task automatic launch(input bit serial, input logic [1:0] core, input logic [19:0] tgt);
        @(negedge clk);
        mode_serial = serial; core_sel = core; target_khz = tgt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic compare(input bit serial, input int core, input longint tgt);
        res_t r;
        longint fpe, dpe;
        string rq;
        r = model(serial, core, tgt);
        fpe = 0; dpe = 0;
        if (r.have) begin
            dpe = longint'(1) << (r.p1 + 15);
            if (serial) fpe = (longint'(1) << (r.n + 15)) | (r.m - 2);
            else        fpe = longint'(CODE_TAB[r.m - 10]) << 8;
        end
        // R3 panel success / R5 serial exactness
        rq = serial ? "R5" : "R3";
        chk(found == r.found, rq, "found", found, r.found);
        // R2 panel limits and clock / R4 serial sweep; R8 zeros when empty
        rq = serial ? "R4" : "R2";
        chk(m_out == r.m, rq, "m_out", m_out, r.m);
        chk(p1_out == r.p1, rq, "p1_out", p1_out, r.p1);
        chk(n_out == r.n, "R7", "n_out", n_out, r.n);
        // R6 panel words / R7 serial words
        rq = serial ? "R7" : "R6";
        chk(fp_word == 32'(fpe), rq, "fp_word", fp_word, fpe);
        chk(dpll_word == 32'(dpe), rq, "dpll_word", dpll_word, dpe);
        if (!r.have) chk((m_out == 0) && (fp_word == 0), "R8", "empty result", fp_word, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit ok;
        logic [7:0]  m_keep;
        logic [31:0] fp_keep, dp_keep;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !done && !found, "R1", "flags", {busy, done, found}, 0);
        chk((m_out == 0) && (n_out == 0) && (p1_out == 0), "R1", "divisors", m_out, 0);
        chk((fp_word == 0) && (dpll_word == 0), "R1", "words", fp_word, 0);

        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].serial, VECS[i].core, VECS[i].tgt);
            wait_done(ok);
            chk(ok, "R10", "search completes", ok, 1);
            chk(!busy, "R10", "busy clear at done", busy, 0);
            compare(VECS[i].serial, VECS[i].core, VECS[i].tgt);
        end

        // R9: start while busy is ignored
        launch(1'b0, 2'd0, 20'd65000);
        repeat (3) @(negedge clk);
        chk(busy, "R9", "busy mid-search", busy, 1);
        mode_serial = 1'b1; core_sel = 2'd2; target_khz = 20'd33000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk(ok, "R9", "search completes", ok, 1);
        compare(1'b0, 0, 65000);

        // R10: outputs hold while done, regardless of input changes
        m_keep = m_out; fp_keep = fp_word; dp_keep = dpll_word;
        target_khz = 20'd77777; mode_serial = 1'b0; core_sel = 2'd1;
        repeat (25) @(negedge clk);
        chk(done && (m_out == m_keep), "R10", "m_out held", m_out, m_keep);
        chk((fp_word == fp_keep) && (dpll_word == dp_keep), "R10", "words held", fp_word, fp_keep);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule